// File: doc/BRIEF.md
# Queued Serial Word Transmitter for ARINC 429

This block accepts 32-bit ARINC 429 words from a host over a 16-bit parallel bus, holds them in a small queue, and shifts them out on two logic-level lines in return-to-zero form. The host writes a word in two halves. The first strobe captures the lower half. The second strobe supplies the upper half and commits the whole word to the queue. An external line driver turns the two lines into the analog bus levels.

When the enable input is high and a word is waiting, the transmitter starts. It then keeps sending queued words back to back, with a fixed null spacing between them, until the queue is empty. The bit cell length is the master clock divided by a fast or a slow ratio. A rate-select input picks the ratio. Bit 32 can be replaced by a generated parity bit. A status output shows when there is nothing left to send.

Top module: `a429_tx_top`

## Requirements
- R1: After reset both serial lines are low, the status output `tx_idle_empty` is high, and the queue is empty.
- R2: A `ld_low` strobe captures `bus_data` as word bits 1–16 (bit 1 = `bus_data[0]`). A later `ld_high` strobe supplies `bus_data` as bits 17–32 (bit 17 = `bus_data[0]`) and commits the 32-bit word to the queue.
- R3: Bits go out bit 1 first. A 1 pulses `tx_one` and a 0 pulses `tx_zero`. The pulse is high for the first half of the bit cell (DIV/2 clocks), and both lines are low for the second half.
- R4: With `rate_slow` = 0 a bit cell lasts DIV_FAST master clocks (default 10).
- R5: With `rate_slow` = 1 a bit cell lasts DIV_SLOW master clocks (default 80). The rate is sampled when a word starts, so changing it mid-word does not alter that word.
- R6: With `parity_on` = 1 when a word starts, bit 32 is sent as odd parity over bits 1–31, making the total count of ones odd. With `parity_on` = 0, bit 32 is sent as written.
- R7: When a queued word follows another, both lines stay low for exactly 4.5 bit cells between the end of the last pulse of one word and the first pulse of the next. That is the half-cell return plus four null bit times.
- R8: No word starts while `tx_enable` is low. Once one has started, the transmitter keeps draining the queue even if `tx_enable` falls.
- R9: The queue holds FIFO_DEPTH whole words in arrival order. An `ld_high` while the queue is full is ignored, and the queued words are sent unchanged.
- R10: `tx_idle_empty` is high only while the queue is empty and no word or null spacing is in progress.
- R11: `tx_one` and `tx_zero` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_data | input | 16 | Parallel half-word from the host |
| ld_low | input | 1 | Strobe: capture bits 1–16 |
| ld_high | input | 1 | Strobe: supply bits 17–32 and commit the word |
| tx_enable | input | 1 | Permit the start of transmission |
| rate_slow | input | 1 | 0: cell of DIV_FAST clocks, 1: cell of DIV_SLOW clocks |
| parity_on | input | 1 | Replace bit 32 with odd parity |
| tx_one | output | 1 | Return-to-zero pulse line for 1 bits |
| tx_zero | output | 1 | Return-to-zero pulse line for 0 bits |
| tx_idle_empty | output | 1 | Queue empty and transmitter idle |

## Verification
The bench builds the block with FIFO_DEPTH = 4 and keeps the default dividers of 10 and 80. The shallow queue lets a fill-to-full and a discarded fifth write be reached in a handful of loads. The real ratios keep the 4.5-cell null spacing and the half-cell pulse width at their true clock counts. A line monitor decodes the serial lines back into words and measures each pulse width, the cell period and the null length. This makes parity, bit order, rate latching mid-word and draining after the enable falls visible at the pins.

// File: rtl/a429_tx_pkg.sv
package a429_tx_pkg;

  typedef enum logic [1:0] {
    SER_IDLE = 2'd0,
    SER_SEND = 2'd1,
    SER_GAP  = 2'd2
  } ser_state_e;

  // Null bit times inserted after every word.
  localparam int unsigned NULL_CELLS = 4;

  // Word as it goes on the line: bit 32 optionally forced to odd parity.
  function automatic logic [31:0] shape_word(input logic [31:0] w, input logic par_en);
    logic [31:0] r;
    r = w;
    if (par_en) r[31] = ~(^w[30:0]);
    return r;
  endfunction

  // Clocks the pulse stays high in a cell of the given length.
  function automatic int unsigned high_span(input int unsigned cell_len);
    return cell_len / 2;
  endfunction

endpackage

// File: rtl/a429_cell_timer.sv
module a429_cell_timer #(
  parameter int unsigned DIV_FAST = 10,
  parameter int unsigned DIV_SLOW = 80
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  input  logic slow_sel,
  output logic cell_end,
  output logic first_half
);
  import a429_tx_pkg::*;

  localparam int unsigned CW = $clog2(DIV_SLOW + 1);
  localparam logic [CW-1:0] LEN_F = CW'(DIV_FAST);
  localparam logic [CW-1:0] LEN_S = CW'(DIV_SLOW);

  logic [CW-1:0] cnt;
  logic [CW-1:0] div_q;
  logic [CW-1:0] half_q;

  always_comb begin
    cell_end   = run && (cnt == div_q - 1'b1);
    first_half = cnt < half_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      div_q  <= LEN_F;
      half_q <= CW'(high_span(DIV_FAST));
    end else if (restart) begin
      cnt    <= '0;
      div_q  <= slow_sel ? LEN_S : LEN_F;
      half_q <= slow_sel ? CW'(high_span(DIV_SLOW)) : CW'(high_span(DIV_FAST));
    end else if (run) begin
      cnt <= cell_end ? '0 : cnt + 1'b1;
    end
  end

  // R4/R5: counter stays inside the latched cell length
  a_r4_cell_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < div_q);

  // R5: cell length only changes on a restart
  a_r5_rate_latched: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(restart) |-> $stable(div_q));

endmodule

// File: rtl/a429_word_fifo.sv
module a429_word_fifo #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_req,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic             empty,
  output logic             full
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    count;
  logic             push_ok;

  always_comb begin
    empty   = (count == '0);
    full    = (count == CW'(DEPTH));
    push_ok = wr_req && !full;
    rd_data = mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (rd_en)   rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      case ({push_ok, rd_en})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R9: a write into a full queue leaves it full and unchanged
  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (full && wr_req && !rd_en) |=> (full && $stable(wr_ptr)));

  // R9: reads only ever happen with data present
  a_r9_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> !empty);

endmodule

// File: rtl/a429_serializer.sv
module a429_serializer #(
  parameter int unsigned DIV_FAST = 10,
  parameter int unsigned DIV_SLOW = 80
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tx_enable,
  input  logic        rate_slow,
  input  logic        parity_on,
  input  logic        q_empty,
  input  logic [31:0] q_data,
  output logic        q_pop,
  output logic        busy,
  output logic        tx_one,
  output logic        tx_zero
);
  import a429_tx_pkg::*;

  localparam logic [1:0] GAP_LAST = 2'(NULL_CELLS - 1);

  ser_state_e  st;
  logic [31:0] shreg;
  logic [4:0]  bit_idx;
  logic [1:0]  gap_idx;
  logic        cell_end, first_half;
  logic        sending, gap_done, take_word;

  always_comb begin
    sending   = (st == SER_SEND);
    busy      = (st != SER_IDLE);
    gap_done  = (st == SER_GAP) && cell_end && (gap_idx == GAP_LAST);
    take_word = !q_empty && (((st == SER_IDLE) && tx_enable) || gap_done);
    q_pop     = take_word;
    tx_one    = sending && first_half && shreg[0];
    tx_zero   = sending && first_half && !shreg[0];
  end

  a429_cell_timer #(.DIV_FAST(DIV_FAST), .DIV_SLOW(DIV_SLOW)) i_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (busy),
    .restart    (take_word),
    .slow_sel   (rate_slow),
    .cell_end   (cell_end),
    .first_half (first_half)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= SER_IDLE;
      shreg   <= '0;
      bit_idx <= '0;
      gap_idx <= '0;
    end else if (take_word) begin
      st      <= SER_SEND;
      shreg   <= shape_word(q_data, parity_on);
      bit_idx <= '0;
    end else begin
      case (st)
        SER_SEND: if (cell_end) begin
          shreg   <= shreg >> 1;
          bit_idx <= bit_idx + 1'b1;
          if (bit_idx == 5'd31) begin
            st      <= SER_GAP;
            gap_idx <= '0;
          end
        end
        SER_GAP: if (cell_end) begin
          gap_idx <= gap_idx + 1'b1;
          if (gap_idx == GAP_LAST) st <= SER_IDLE;
        end
        default: st <= SER_IDLE;
      endcase
    end
  end

  // R8: a fresh start always follows a cycle with the enable high
  a_r8_start_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(tx_enable));

  // R11: the two lines are mutually exclusive
  a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_one && tx_zero));

  // R7: the null spacing never carries a pulse
  a_r7_gap_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SER_GAP) |-> !(tx_one || tx_zero));

endmodule

// File: rtl/a429_tx_top.sv
module a429_tx_top #(
  parameter int unsigned FIFO_DEPTH = 8,
  parameter int unsigned DIV_FAST   = 10,
  parameter int unsigned DIV_SLOW   = 80
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] bus_data,
  input  logic        ld_low,
  input  logic        ld_high,
  input  logic        tx_enable,
  input  logic        rate_slow,
  input  logic        parity_on,
  output logic        tx_one,
  output logic        tx_zero,
  output logic        tx_idle_empty
);
  logic [15:0] low_hold;
  logic [31:0] q_data;
  logic        q_empty, q_full, q_pop, busy;

  always_ff @(posedge clk) begin
    if (!rst_n)      low_hold <= '0;
    else if (ld_low) low_hold <= bus_data;
  end

  a429_word_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(32)) i_fifo (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_req  (ld_high),
    .wr_data ({bus_data, low_hold}),
    .rd_en   (q_pop),
    .rd_data (q_data),
    .empty   (q_empty),
    .full    (q_full)
  );

  a429_serializer #(.DIV_FAST(DIV_FAST), .DIV_SLOW(DIV_SLOW)) i_ser (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_enable (tx_enable),
    .rate_slow (rate_slow),
    .parity_on (parity_on),
    .q_empty   (q_empty),
    .q_data    (q_data),
    .q_pop     (q_pop),
    .busy      (busy),
    .tx_one    (tx_one),
    .tx_zero   (tx_zero)
  );

  assign tx_idle_empty = q_empty && !busy;

  // R10: status and a full queue are exclusive
  a_r10_status_consistent: assert property (@(posedge clk) disable iff (!rst_n)
    tx_idle_empty |-> !q_full && !tx_one && !tx_zero);

endmodule

// File: tb/test_a429_tx_top.sv
module test_a429_tx_top;
  localparam int DEPTH = 4;
  localparam int DF = 10;
  localparam int DS = 80;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] bus_data = '0;
  logic ld_low = 1'b0, ld_high = 1'b0, tx_enable = 1'b0, rate_slow = 1'b0, parity_on = 1'b0;
  logic tx_one, tx_zero, tx_idle_empty;

  always #2.5 clk = ~clk;

  a429_tx_top #(.FIFO_DEPTH(DEPTH), .DIV_FAST(DF), .DIV_SLOW(DS)) i_a429_tx_top (
    .clk(clk), .rst_n(rst_n), .bus_data(bus_data), .ld_low(ld_low), .ld_high(ld_high),
    .tx_enable(tx_enable), .rate_slow(rate_slow), .parity_on(parity_on),
    .tx_one(tx_one), .tx_zero(tx_zero), .tx_idle_empty(tx_idle_empty)
  );

  int total = 0, bad = 0, cyc = 0;

  // stimulus word, parity, slow, expected line word
  typedef struct packed { logic [31:0] w; logic par; logic slow; logic [31:0] exp; } vec_t;
  localparam vec_t VECS [6] = '{
    '{32'h8000_0001, 1'b0, 1'b0, 32'h8000_0001},
    '{32'h0000_0001, 1'b1, 1'b0, 32'h0000_0001},
    '{32'h0000_0003, 1'b1, 1'b0, 32'h8000_0003},
    '{32'hA5A5_5A5A, 1'b1, 1'b1, 32'h25A5_5A5A},
    '{32'hFFFF_FFFF, 1'b0, 1'b1, 32'hFFFF_FFFF},
    '{32'h0123_4567, 1'b1, 1'b0, 32'h8123_4567}
  };

  // line monitor
  logic [31:0] rx_word [64];
  int rx_gap [64], rx_pmin [64], rx_pmax [64], rx_high [64];
  int rx_n = 0, rises = 0, both_hi = 0;
  logic [31:0] cur_word = '0;
  int bcnt = 0, low_run = 0, high_run = 0, last_high = 0, last_rise = 0, pmin = 0, pmax = 0, cur_gap = 0;
  logic prev_act = 1'b0;

  always @(negedge clk) begin
    logic act;
    int p;
    cyc++;
    act = tx_one | tx_zero;
    if (rst_n) begin
      if (tx_one && tx_zero) both_hi++;
      if (act && !prev_act) begin
        rises++;
        if (bcnt == 0) begin
          cur_gap = low_run; pmin = 99999; pmax = 0;
        end else begin
          p = cyc - last_rise;
          if (p < pmin) pmin = p;
          if (p > pmax) pmax = p;
        end
        last_rise = cyc;
        cur_word[bcnt] = tx_one;
        if (bcnt == 31) begin
          if (rx_n < 64) begin
            rx_word[rx_n] = cur_word; rx_gap[rx_n] = cur_gap;
            rx_pmin[rx_n] = pmin; rx_pmax[rx_n] = pmax; rx_high[rx_n] = last_high;
          end
          rx_n++;
          bcnt = 0;
        end else bcnt++;
      end
      if (act) begin high_run++; low_run = 0; end
      else begin
        if (prev_act) last_high = high_run;
        high_run = 0; low_run++;
      end
    end
    prev_act = act;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic load_word(input logic [31:0] w);
    @(negedge clk); bus_data = w[15:0]; ld_low = 1'b1;
    @(negedge clk); ld_low = 1'b0; bus_data = w[31:16]; ld_high = 1'b1;
    @(negedge clk); ld_high = 1'b0; bus_data = '0;
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 20000; k++) begin
      @(negedge clk);
      if (tx_idle_empty) return;
    end
  endtask

  initial begin
    #(150000 * 5);
    bad++; total++;
    $display("FAIL watchdog actual=%0d expected=done", cyc);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int base, r0;
    logic [31:0] fw [5];
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(tx_one == 0 && tx_zero == 0, "R1 lines low", {tx_one, tx_zero}, 0);
    chk(tx_idle_empty == 1, "R1/R10 status after reset", tx_idle_empty, 1);

    // table walk: R2 R3 R4 R5 R6 R8 R10
    for (int i = 0; i < 6; i++) begin
      parity_on = VECS[i].par; rate_slow = VECS[i].slow;
      base = rx_n; r0 = rises;
      load_word(VECS[i].w);
      chk(tx_idle_empty == 0, "R10 status drops with queued word", tx_idle_empty, 0);
      repeat (30) @(negedge clk);
      chk(rises == r0, "R8 no start while disabled", rises - r0, 0);
      tx_enable = 1'b1;
      @(negedge clk);
      wait_idle();
      tx_enable = 1'b0;
      chk(rx_n == base + 1, "R2 one word sent", rx_n - base, 1);
      chk(rx_word[base] == VECS[i].exp, "R2/R3/R6 word content", rx_word[base], VECS[i].exp);
      if (VECS[i].slow) begin
        chk(rx_pmin[base] == DS && rx_pmax[base] == DS, "R5 slow cell", rx_pmax[base], DS);
        chk(rx_high[base] == DS / 2, "R3 slow half-cell pulse", rx_high[base], DS / 2);
      end else begin
        chk(rx_pmin[base] == DF && rx_pmax[base] == DF, "R4 fast cell", rx_pmax[base], DF);
        chk(rx_high[base] == DF / 2, "R3 fast half-cell pulse", rx_high[base], DF / 2);
      end
    end

    // R7 R8: back to back, enable dropped early
    parity_on = 1'b0; rate_slow = 1'b0;
    base = rx_n;
    load_word(32'h1111_0001); load_word(32'h2222_0002); load_word(32'h4444_0004);
    tx_enable = 1'b1; repeat (5) @(negedge clk); tx_enable = 1'b0;
    wait_idle();
    chk(rx_n == base + 3, "R8 drains after enable falls", rx_n - base, 3);
    chk(rx_word[base + 2] == 32'h4444_0004, "R9 order kept", rx_word[base + 2], 32'h4444_0004);
    chk(rx_gap[base + 1] == 4 * DF + DF / 2, "R7 null spacing word 2", rx_gap[base + 1], 4 * DF + DF / 2);
    chk(rx_gap[base + 2] == 4 * DF + DF / 2, "R7 null spacing word 3", rx_gap[base + 2], 4 * DF + DF / 2);

    // R9: fill past depth
    base = rx_n;
    for (int k = 0; k < 5; k++) begin
      fw[k] = 32'h0F00_0000 + 32'(k * 257 + 3);
      load_word(fw[k]);
    end
    tx_enable = 1'b1; @(negedge clk); tx_enable = 1'b0;
    wait_idle();
    repeat (20) @(negedge clk);
    chk(rx_n == base + DEPTH, "R9 fifth write ignored", rx_n - base, DEPTH);
    for (int k = 0; k < DEPTH; k++)
      chk(rx_word[base + k] == fw[k], "R9 queued word intact", rx_word[base + k], fw[k]);

    // R5: rate change mid-word has no effect on that word
    base = rx_n; rate_slow = 1'b0;
    load_word(32'h5A5A_0F0F);
    tx_enable = 1'b1; @(negedge clk); tx_enable = 1'b0;
    repeat (100) @(negedge clk);
    rate_slow = 1'b1;
    wait_idle();
    rate_slow = 1'b0;
    chk(rx_pmin[base] == DF && rx_pmax[base] == DF, "R5 rate latched per word", rx_pmax[base], DF);
    chk(rx_word[base] == 32'h5A5A_0F0F, "R6 parity off keeps bit 32", rx_word[base], 32'h5A5A_0F0F);

    // R11 / R1
    chk(both_hi == 0, "R11 lines exclusive", both_hi, 0);
    chk(tx_idle_empty == 1 && !tx_one && !tx_zero, "R10 idle at end", tx_idle_empty, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule